// File: doc/BRIEF.md
# Serial-Bus Wiper Register Controller

This block is a two-wire serial bus slave that owns one 7-bit volatile wiper register for a digitally controlled resistor divider. The bus lines are sampled with a fast system clock. Each line passes through a two-flop synchronizer and a glitch filter, and then the block detects SCL edges and the START and STOP conditions. The wiper value goes out on a parallel port that feeds a tap decoder.

A host sets the wiper with a three-byte transfer: the device identifier with the write flag, register address 00h, then the data byte. The value takes effect on the SCL falling edge that ends the last data bit. To read the wiper, the host first writes the identifier and address (a dummy write), then issues a repeated START and the identifier with the read flag. The slave then sends the wiper value for as long as the host acknowledges. Any other identifier or address is refused, and the slave stays silent until the next START.

Top module: `i2c_wiper_ctrl`

## Requirements
- R1: A synchronous active-high reset presets the wiper to 40h (midscale) and releases SDA (sda_oe = 0).
- R2: The first byte after a START is compared, MSB first, against the 7-bit identifier 0101110 in bits 7:1. A parameter selects 0111110 instead. Bit 0 is the direction flag (0 = write, 1 = read). On a match the slave pulls SDA low in the ninth clock. On a mismatch it leaves SDA released and ignores everything until the next START.
- R3: The byte that follows an accepted write identifier is the register address. Only 00h is acknowledged. Any other value is refused, and the data byte that follows is neither acknowledged nor stored.
- R4: The data byte of a write is acknowledged. Its bits 6:0 become the wiper value, and its bit 7 is ignored.
- R5: The wiper changes on the SCL falling edge that ends the LSB of the data byte, before the acknowledge clock and before STOP, and at no other moment.
- R6: After a dummy write of address 00h and a repeated START, an identifier with the read flag is acknowledged. The slave then sends the byte {0, wiper} MSB first.
- R7: While the host acknowledges (SDA low in the ninth clock), the slave sends the same byte again. A host not-acknowledge makes the slave release SDA and wait for STOP.
- R8: A read identifier is refused when no address 00h was accepted since the last STOP.
- R9: A START seen at any point, including mid-byte, aborts the current byte and restarts identifier reception. A STOP returns the slave to idle with SDA released. Neither condition drives SDA.
- R10: A pulse on SDA or SCL shorter than FILT_LEN system clocks is suppressed and does not disturb a transfer.
- R11: sda_oe changes only right after an SCL falling edge, a START or a STOP. It never changes while SCL is high within a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Serial clock as seen on the pad |
| sda_in | input | 1 | Serial data as seen on the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| wiper | output | 7 | Current wiper tap position |

## Verification
The hardest case to reach is the exact moment of the wiper update. The bench must show that the new value appears after the falling edge of the last data bit and before both the acknowledge clock and STOP. The master task samples the wiper while SCL is still high on that last bit, and samples it again late in the following low phase, before the ninth rising edge. The glitch case is hard in a similar way. An inverted SDA pulse shorter than the filter is placed while the filtered SCL is high, so without the filter it would look like a START or STOP in the middle of the data byte.

// File: rtl/wpi_pkg.sv
package wpi_pkg;
  localparam int BYTE_W = 8;
  localparam logic [6:0] ID_MAIN = 7'b0101110;
  localparam logic [6:0] ID_ALT  = 7'b0111110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_SKIP
  } link_state_t;

  typedef enum logic [1:0] {
    PH_ID,
    PH_ADDR,
    PH_DATA
  } link_phase_t;
endpackage

// File: rtl/wpi_line_filter.sv
module wpi_line_filter #(
  parameter int FILT_LEN = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic         s1, s2;
  logic [CW-1:0] cnt;

  // two-flop synchronizer, bus idles high
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end
  end

  // level must differ for FILT_LEN consecutive clocks before it is accepted
  always_ff @(posedge clk) begin
    if (rst) begin
      clean <= 1'b1;
      cnt   <= '0;
    end else if (s2 == clean) begin
      cnt <= '0;
    end else if (cnt == CW'(FILT_LEN - 1)) begin
      clean <= s2;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wpi_bus_events.sv
module wpi_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_c,
  input  logic sda_c,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_c;
      sda_q <= sda_c;
    end
  end

  always_comb begin
    scl_rise = scl_c & ~scl_q;
    scl_fall = ~scl_c & scl_q;
    start_ev = scl_c & scl_q & sda_q & ~sda_c;
    stop_ev  = scl_c & scl_q & ~sda_q & sda_c;
  end
endmodule

// File: rtl/wpi_link_fsm.sv
module wpi_link_fsm
  import wpi_pkg::*;
#(
  parameter int WIPER_W    = 7,
  parameter bit USE_ALT_ID = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sda_c,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_ev,
  input  logic               stop_ev,
  output logic               sda_oe,
  output logic [WIPER_W-1:0] wiper
);
  localparam logic [6:0]         DEV_ID   = USE_ALT_ID ? ID_ALT : ID_MAIN;
  localparam logic [WIPER_W-1:0] MIDSCALE = WIPER_W'(1) << (WIPER_W - 1);

  link_state_t       state;
  link_phase_t       phase;
  logic [BYTE_W-1:0] shreg;
  logic [3:0]        bitcnt;
  logic              is_read;
  logic              addr_ok;
  logic              mack;
  logic [BYTE_W-1:0] rd_word;

  assign rd_word = BYTE_W'(wiper);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      phase   <= PH_ID;
      shreg   <= '0;
      bitcnt  <= '0;
      is_read <= 1'b0;
      addr_ok <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
      wiper   <= MIDSCALE;
    end else if (start_ev) begin
      state  <= ST_RX;
      phase  <= PH_ID;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      state   <= ST_IDLE;
      addr_ok <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_c};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            unique case (phase)
              PH_ID: begin
                if (shreg[7:1] == DEV_ID && (!shreg[0] || addr_ok)) begin
                  is_read <= shreg[0];
                  sda_oe  <= 1'b1;
                  state   <= ST_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end
              PH_ADDR: begin
                if (shreg == '0) begin
                  addr_ok <= 1'b1;
                  sda_oe  <= 1'b1;
                  state   <= ST_ACK;
                end else begin
                  addr_ok <= 1'b0;
                  state   <= ST_SKIP;
                end
              end
              default: begin
                wiper  <= shreg[WIPER_W-1:0];
                sda_oe <= 1'b1;
                state  <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            unique case (phase)
              PH_ID: begin
                if (is_read) begin
                  shreg  <= rd_word;
                  sda_oe <= ~rd_word[BYTE_W-1];
                  state  <= ST_TX;
                end else begin
                  sda_oe <= 1'b0;
                  phase  <= PH_ADDR;
                  state  <= ST_RX;
                end
              end
              PH_ADDR: begin
                sda_oe <= 1'b0;
                phase  <= PH_DATA;
                state  <= ST_RX;
              end
              default: begin
                sda_oe <= 1'b0;
                state  <= ST_SKIP;
              end
            endcase
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_TXACK;
            end else begin
              shreg  <= {shreg[BYTE_W-2:0], 1'b0};
              sda_oe <= ~shreg[BYTE_W-2];
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            mack <= ~sda_c;
          end else if (scl_fall) begin
            if (mack) begin
              shreg  <= rd_word;
              sda_oe <= ~rd_word[BYTE_W-1];
              bitcnt <= '0;
              state  <= ST_TX;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_wiper_ctrl.sv
module i2c_wiper_ctrl #(
  parameter int WIPER_W    = 7,
  parameter int FILT_LEN   = 13,
  parameter bit USE_ALT_ID = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  output logic [WIPER_W-1:0] wiper
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] clean_lines;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    wpi_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .raw  (raw_lines[g]),
      .clean(clean_lines[g])
    );
  end

  wpi_bus_events u_events (
    .clk     (clk),
    .rst     (rst),
    .scl_c   (clean_lines[0]),
    .sda_c   (clean_lines[1]),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  wpi_link_fsm #(.WIPER_W(WIPER_W), .USE_ALT_ID(USE_ALT_ID)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .sda_c   (clean_lines[1]),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev),
    .sda_oe  (sda_oe),
    .wiper   (wiper)
  );
endmodule

// File: rtl/wpi_checker.sv
module wpi_checker #(
  parameter int WIPER_W = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               scl_fall,
  input logic               start_ev,
  input logic               stop_ev,
  input logic               sda_oe,
  input logic [WIPER_W-1:0] wiper
);
  localparam logic [WIPER_W-1:0] MID = WIPER_W'(1) << (WIPER_W - 1);

  logic rst_q = 1'b0;

  always @(posedge clk) begin
    rst_q <= rst;
    if (rst_q && !rst) begin
      AST_RESET_MIDSCALE: assert (wiper == MID && !sda_oe) else $error("reset preset"); // R1
    end
  end

  AST_WIPER_AT_SCL_FALL: assert property (@(posedge clk) disable iff (rst)
    (wiper != $past(wiper)) |-> $past(scl_fall)); // R5

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !sda_oe); // R9

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> !sda_oe); // R9

  AST_COND_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(start_ev && stop_ev)); // R9

  AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_ev || stop_ev)); // R11
endmodule

bind i2c_wiper_ctrl wpi_checker #(.WIPER_W(WIPER_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .scl_fall(scl_fall),
  .start_ev(start_ev),
  .stop_ev (stop_ev),
  .sda_oe  (sda_oe),
  .wiper   (wiper)
);

// File: tb/sim_i2c_wiper_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_wiper_ctrl;
  localparam int HP = 40;
  localparam int NVEC = 6;
  localparam logic [7:0] ID_W = {7'b0101110, 1'b0};
  localparam logic [7:0] ID_R = {7'b0101110, 1'b1};
  // {data byte written, expected wiper}
  localparam logic [14:0] VEC [NVEC] = '{
    {8'h00, 7'h00}, {8'h7F, 7'h7F}, {8'hFF, 7'h7F},
    {8'h80, 7'h00}, {8'h2A, 7'h2A}, {8'hD5, 7'h55}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [6:0] wiper;
  wire  sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_n = 0;
  bit glitch_en = 1'b0;
  bit hi_err = 1'b0;
  logic [6:0] pre_w, post_w;

  always #2 clk = ~clk;

  i2c_wiper_ctrl u0 (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .wiper(wiper)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; cyc(HP);
    scl_m = 1'b1; cyc(HP);
    sda_m = 1'b0; cyc(HP);
    scl_m = 1'b0; cyc(HP / 2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; cyc(HP);
    scl_m = 1'b1; cyc(HP);
    sda_m = 1'b1; cyc(HP);
  endtask

  task automatic tx_bit(input logic b);
    sda_m = b; cyc(HP);
    scl_m = 1'b1; cyc(HP);
    scl_m = 1'b0;
  endtask

  task automatic tx_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; cyc(HP);
      scl_m = 1'b1;
      if (glitch_en && i == 7) begin
        cyc(25); sda_m = ~b[i]; cyc(4); sda_m = b[i]; cyc(HP - 29);
      end else begin
        cyc(HP);
      end
      if (i == 0) pre_w = wiper;
      scl_m = 1'b0;
    end
    sda_m = 1'b1; cyc(HP);
    post_w = wiper;
    ack = ~sda_line;
    scl_m = 1'b1; cyc(HP);
    scl_m = 1'b0;
  endtask

  task automatic rx_byte(input bit mack, output logic [7:0] b);
    logic s0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; cyc(HP);
      scl_m = 1'b1; cyc(HP / 2);
      s0 = sda_line; cyc(HP / 2 - 1);
      if (s0 != sda_line) hi_err = 1'b1;
      b[i] = s0;
      cyc(1);
      scl_m = 1'b0;
    end
    sda_m = ~mack; cyc(HP);
    scl_m = 1'b1; cyc(HP);
    scl_m = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d, output bit a1, output bit a2, output bit a3);
    bus_start();
    tx_byte(ID_W, a1);
    tx_byte(8'h00, a2);
    tx_byte(d, a3);
    bus_stop();
  endtask

  task automatic do_read(output bit a1, output bit a2, output bit a3, output logic [7:0] b);
    bus_start();
    tx_byte(ID_W, a1);
    tx_byte(8'h00, a2);
    bus_start();
    tx_byte(ID_R, a3);
    rx_byte(1'b0, b);
    bus_stop();
  endtask

  initial begin : watchdog
    while (cyc_n < 150000) begin
      @(posedge clk);
      cyc_n++;
    end
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog actual=%0d expected=below %0d", cyc_n, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    bit a1, a2, a3;
    logic [7:0] b1, b2, b3;
    logic [6:0] prev;

    cyc(5); rst = 1'b0; cyc(3);
    chk(wiper == 7'h40, "R1 reset wiper", wiper, 7'h40);
    chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);

    // vector table: write then read back
    prev = wiper;
    for (int v = 0; v < NVEC; v++) begin
      do_write(VEC[v][14:7], a1, a2, a3);
      chk(a1, "R2 id ack", a1, 1);
      chk(a2, "R3 addr ack", a2, 1);
      chk(a3, "R4 data ack", a3, 1);
      chk(wiper == VEC[v][6:0], "R4 wiper value", wiper, VEC[v][6:0]);
      chk(pre_w == prev, "R5 wiper before last fall", pre_w, prev);
      chk(post_w == VEC[v][6:0], "R5 wiper before ack clock", post_w, VEC[v][6:0]);
      do_read(a1, a2, a3, b1);
      chk(a1 && a2 && a3, "R6 read acks", {a1, a2, a3}, 3'b111);
      chk(b1 == {1'b0, VEC[v][6:0]}, "R6 read byte", b1, {1'b0, VEC[v][6:0]});
      prev = VEC[v][6:0];
    end

    // streaming read with host acks then nack
    do_write(8'h3C, a1, a2, a3);
    bus_start();
    tx_byte(ID_W, a1);
    tx_byte(8'h00, a2);
    bus_start();
    tx_byte(ID_R, a3);
    rx_byte(1'b1, b1);
    rx_byte(1'b1, b2);
    rx_byte(1'b0, b3);
    cyc(HP);
    chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
    scl_m = 1'b1; cyc(HP);
    chk(sda_line == 1'b1, "R7 waits for stop", sda_line, 1);
    scl_m = 1'b0; cyc(HP);
    bus_stop();
    chk(b1 == 8'h3C && b2 == 8'h3C && b3 == 8'h3C, "R7 repeated bytes", {b1, b2, b3}, 24'h3C3C3C);
    chk(!hi_err, "R11 sda stable while scl high", hi_err, 0);

    // read identifier without accepted address
    bus_start();
    tx_byte(ID_R, a1);
    chk(!a1, "R8 read id refused", a1, 0);
    tx_byte(8'h00, a2);
    chk(!a2, "R8 rest ignored", a2, 0);
    bus_stop();

    // wrong identifier (alternate id is not selected by default)
    bus_start();
    tx_byte({7'b0111110, 1'b0}, a1);
    tx_byte(8'h00, a2);
    tx_byte(8'h11, a3);
    bus_stop();
    chk(!a1 && !a2 && !a3, "R2 mismatch nack", {a1, a2, a3}, 0);
    chk(wiper == 7'h3C, "R2 wiper untouched", wiper, 7'h3C);

    // bad register address
    bus_start();
    tx_byte(ID_W, a1);
    tx_byte(8'h01, a2);
    tx_byte(8'h22, a3);
    bus_stop();
    chk(a1 && !a2, "R3 addr 01h refused", {a1, a2}, 2'b10);
    chk(!a3, "R3 data not acked", a3, 0);
    chk(wiper == 7'h3C, "R3 wiper untouched", wiper, 7'h3C);

    // repeated START in the middle of a byte aborts it
    bus_start();
    tx_byte(ID_W, a1);
    tx_bit(1'b1); tx_bit(1'b0); tx_bit(1'b1);
    bus_start();
    tx_byte(ID_W, a1);
    tx_byte(8'h00, a2);
    tx_byte(8'h33, a3);
    bus_stop();
    chk(a1 && a2 && a3, "R9 acks after abort", {a1, a2, a3}, 3'b111);
    chk(wiper == 7'h33, "R9 wiper after abort", wiper, 7'h33);

    // STOP right after identifier
    bus_start();
    tx_byte(ID_W, a1);
    bus_stop();
    chk(sda_oe == 1'b0, "R9 stop releases", sda_oe, 0);
    chk(wiper == 7'h33, "R9 wiper kept on early stop", wiper, 7'h33);

    // short SDA pulse while SCL high must be filtered
    glitch_en = 1'b1;
    do_write(8'h5A, a1, a2, a3);
    glitch_en = 1'b0;
    chk(a1 && a2 && a3, "R10 acks with glitch", {a1, a2, a3}, 3'b111);
    chk(wiper == 7'h5A, "R10 wiper with glitch", wiper, 7'h5A);

    // mid-run reset
    rst = 1'b1; cyc(4); rst = 1'b0; cyc(2);
    chk(wiper == 7'h40, "R1 reset after use", wiper, 7'h40);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule